// File: doc/BRIEF.md
# Ramp, Dwell and Freeze Setpoint Sequencer

This block produces the digital setpoint word for a supply. At rest the word is zero. A start request sends the block into a climbing phase, in which the word grows by a programmable increment on every clock cycle until it meets a programmable ceiling. The block then rests on the ceiling for a programmable number of cycles and drops back to rest on its own. No further request is needed for that return.

Two requests can interrupt the climb. A pause request freezes the word at the value it has reached, and a later start request continues the climb from that value. An off request returns the block to rest and zeroes the word from any active phase, and it overrides a start request that arrives in the same cycle. A two-bit phase code reports the current phase so that neighbouring logic can follow the sequence.

Top module: `rhc_ramp_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block goes to the rest phase (phase code 0) and `level_o` becomes 0 at that edge.
- R2: In the rest phase (code 0), `level_o` is 0 and the phase stays 0 until a start request arrives. A pause request in the rest phase has no effect.
- R3: A start request in the rest phase moves the block to the climb phase (code 1) at the next edge, with `level_o` still 0. On each following edge in the climb phase, `level_o` grows by `step_i`. A start request during the climb has no effect.
- R4: In the climb phase, if `level_o + step_i`, computed without wrap-around, is at least `target_i`, the next edge sets `level_o` to exactly `target_i` and enters the dwell phase (code 2).
- R5: The dwell phase lasts `dwell_i` cycles, with `dwell_i` sampled at the edge that enters it, and a value of 0 counts as 1. During the dwell, `level_o` holds the ceiling. The block then returns to code 0 with `level_o` at 0. Pause and start requests during the dwell have no effect.
- R6: A pause request in the climb phase moves the block to the freeze phase (code 3) at the next edge, and `level_o` keeps its value. The block stays frozen until a start or off request arrives.
- R7: A start request in the freeze phase returns the block to code 1 with the frozen value unchanged. The climb then continues from that value on the next edge.
- R8: An off request in code 1, 2 or 3 moves the block to code 0 and sets `level_o` to 0 at the next edge.
- R9: When start and off are both asserted in the same cycle, off takes effect and start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start or resume request |
| pause_i | input | 1 | Freeze request during the climb |
| off_i | input | 1 | Return-to-rest request |
| target_i | input | LEVEL_W | Ceiling of the climb |
| step_i | input | LEVEL_W | Increment per climb cycle |
| dwell_i | input | DWELL_W | Dwell length in cycles |
| level_o | output | LEVEL_W | Setpoint word |
| phase_o | output | 2 | Phase code: 0 rest, 1 climb, 2 dwell, 3 freeze |

## Verification
The sequence is tried with a ceiling that the increments miss, which separates clamping from plain counting. It is also tried with an increment large enough that the unclamped sum would wrap the word, which shows whether the comparison is made at full width. Pause, resume and off requests are each applied in every phase, so a request that is honoured in the wrong phase shows up as a wrong phase code or level. Dwell lengths of 0, 1 and 5 are measured in cycles, which exposes off-by-one errors in the countdown. Coincident start and off requests in the rest and climb phases show whether off takes priority.

// File: rtl/rhc_pkg.sv
// Shared types for the ramp/dwell/freeze setpoint sequencer.
// Assumes: phase codes are observed by neighbouring logic, so the
// encoding below is fixed.
package rhc_pkg;

    typedef enum logic [1:0] {
        PH_REST   = 2'd0,
        PH_CLIMB  = 2'd1,
        PH_DWELL  = 2'd2,
        PH_FREEZE = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        LVL_KEEP    = 2'd0,
        LVL_CLEAR   = 2'd1,
        LVL_ADVANCE = 2'd2
    } lvl_cmd_e;

endpackage

// File: rtl/rhc_level_acc.sv
// Setpoint accumulator: holds the setpoint word, adds the step on command
// and clamps to the ceiling. The sum is formed one bit wider than the
// word, so a large step cannot wrap past the ceiling.
// Assumes: the command comes from the sequencer, one per cycle.
module rhc_level_acc
    import rhc_pkg::*;
#(
    parameter int LEVEL_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  lvl_cmd_e           cmd_i,
    input  logic [LEVEL_W-1:0] target_i,
    input  logic [LEVEL_W-1:0] step_i,
    output logic [LEVEL_W-1:0] level_o,
    output logic               reach_o
);
    localparam int SUM_W = LEVEL_W + 1;

    logic [SUM_W-1:0] sum;

    // Form the unclamped next value and compare it with the ceiling.
    always_comb begin
        sum     = {1'b0, level_o} + {1'b0, step_i};
        reach_o = (sum >= {1'b0, target_i});
    end

    // Update the setpoint word according to the sequencer command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o <= '0;
        end else begin
            unique case (cmd_i)
                LVL_CLEAR:   level_o <= '0;
                LVL_ADVANCE: level_o <= reach_o ? target_i : sum[LEVEL_W-1:0];
                default:     level_o <= level_o;
            endcase
        end
    end

endmodule

// File: rtl/rhc_dwell_timer.sv
// Dwell countdown: loads the dwell length on entry and counts down by one
// per dwell cycle. last_o marks the final dwell cycle; a length of zero
// behaves like one.
// Assumes: load and dec are never asserted together.
module rhc_dwell_timer #(
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               dec_i,
    input  logic [DWELL_W-1:0] len_i,
    output logic               last_o
);
    logic [DWELL_W-1:0] cnt;

    // Hold or count down the remaining dwell cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= len_i;
        end else if (dec_i && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Flag the cycle in which the remaining count is one or less.
    always_comb begin
        last_o = (cnt <= DWELL_W'(1));
    end

endmodule

// File: rtl/rhc_sequencer.sv
// Phase sequencer: decides the phase and issues commands to the
// accumulator and the dwell timer. Off has priority over every other
// request; pause is honoured only while climbing.
// Assumes: requests are already synchronous to clk.
module rhc_sequencer
    import rhc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     pause_i,
    input  logic     off_i,
    input  logic     reach_i,
    input  logic     dwell_last_i,
    output phase_e   phase_o,
    output lvl_cmd_e lvl_cmd_o,
    output logic     dwell_load_o,
    output logic     dwell_dec_o
);
    phase_e nxt;

    // Choose the next phase and the commands for this cycle.
    always_comb begin
        nxt          = phase_o;
        lvl_cmd_o    = LVL_KEEP;
        dwell_load_o = 1'b0;
        dwell_dec_o  = 1'b0;
        unique case (phase_o)
            PH_REST: begin
                lvl_cmd_o = LVL_CLEAR;
                if (start_i && !off_i) nxt = PH_CLIMB;
            end
            PH_CLIMB: begin
                if (off_i) begin
                    nxt       = PH_REST;
                    lvl_cmd_o = LVL_CLEAR;
                end else if (pause_i) begin
                    nxt = PH_FREEZE;
                end else begin
                    lvl_cmd_o = LVL_ADVANCE;
                    if (reach_i) begin
                        nxt          = PH_DWELL;
                        dwell_load_o = 1'b1;
                    end
                end
            end
            PH_DWELL: begin
                if (off_i || dwell_last_i) begin
                    nxt       = PH_REST;
                    lvl_cmd_o = LVL_CLEAR;
                end else begin
                    dwell_dec_o = 1'b1;
                end
            end
            PH_FREEZE: begin
                if (off_i) begin
                    nxt       = PH_REST;
                    lvl_cmd_o = LVL_CLEAR;
                end else if (start_i) begin
                    nxt = PH_CLIMB;
                end
            end
            default: nxt = PH_REST;
        endcase
    end

    // Register the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_o <= PH_REST;
        else        phase_o <= nxt;
    end

endmodule

// File: rtl/rhc_ramp_ctrl.sv
// Top of the setpoint sequencer: joins the phase sequencer, the clamped
// accumulator and the dwell countdown.
// Assumes: target, step and dwell are held steady by the user while they
// matter; a zero step with a non-zero ceiling climbs forever.
module rhc_ramp_ctrl
    import rhc_pkg::*;
#(
    parameter int LEVEL_W = 12,
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               pause_i,
    input  logic               off_i,
    input  logic [LEVEL_W-1:0] target_i,
    input  logic [LEVEL_W-1:0] step_i,
    input  logic [DWELL_W-1:0] dwell_i,
    output logic [LEVEL_W-1:0] level_o,
    output logic [1:0]         phase_o
);
    phase_e   phase;
    lvl_cmd_e lvl_cmd;
    logic     reach;
    logic     dwell_last;
    logic     dwell_load;
    logic     dwell_dec;

    rhc_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .pause_i      (pause_i),
        .off_i        (off_i),
        .reach_i      (reach),
        .dwell_last_i (dwell_last),
        .phase_o      (phase),
        .lvl_cmd_o    (lvl_cmd),
        .dwell_load_o (dwell_load),
        .dwell_dec_o  (dwell_dec)
    );

    rhc_level_acc #(.LEVEL_W(LEVEL_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (lvl_cmd),
        .target_i (target_i),
        .step_i   (step_i),
        .level_o  (level_o),
        .reach_o  (reach)
    );

    rhc_dwell_timer #(.DWELL_W(DWELL_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (dwell_load),
        .dec_i  (dwell_dec),
        .len_i  (dwell_i),
        .last_o (dwell_last)
    );

    // Expose the phase as a plain code.
    always_comb phase_o = phase;

endmodule

// File: rtl/rhc_checker.sv
// Property checker for the setpoint sequencer, attached to the top
// by bind. Phase codes: 0 rest, 1 climb, 2 dwell, 3 freeze.
module rhc_checker #(
    parameter int LEVEL_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               off_i,
    input logic [LEVEL_W-1:0] target_i,
    input logic [LEVEL_W-1:0] level_o,
    input logic [1:0]         phase_o
);
    // R2
    rest_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 2'd0 |-> level_o == '0);

    // R2
    rest_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd0 && !start_i) |=> phase_o == 2'd0);

    // R8
    off_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_i |=> (phase_o == 2'd0 && level_o == '0));

    // R3
    climb_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd1 && $past(phase_o) == 2'd1 && $stable(target_i))
        |-> level_o >= $past(level_o));

    // R4
    dwell_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2 && $past(phase_o) == 2'd1)
        |-> level_o == $past(target_i));

    // R6
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3 && $past(phase_o) == 2'd3) |-> $stable(level_o));

    // R5
    dwell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2 && $past(phase_o) == 2'd2) |-> $stable(level_o));

endmodule

bind rhc_ramp_ctrl rhc_checker #(.LEVEL_W(LEVEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .off_i    (off_i),
    .target_i (target_i),
    .level_o  (level_o),
    .phase_o  (phase_o)
);

// File: tb/rhc_ramp_ctrl_test.sv
// Bench: a vector table walked by one loop, then directed corner tests.
module rhc_ramp_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 12;
    localparam int DW = 16;
    localparam int NVEC = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, pause_i = 1'b0, off_i = 1'b0;
    logic [LW-1:0] target_i = 12'd10, step_i = 12'd3;
    logic [DW-1:0] dwell_i = 16'd3;
    logic [LW-1:0] level_o;
    logic [1:0]    phase_o;

    int n_cmp = 0;
    int n_bad = 0;

    rhc_ramp_ctrl #(.LEVEL_W(LW), .DWELL_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pause_i(pause_i),
        .off_i(off_i), .target_i(target_i), .step_i(step_i),
        .dwell_i(dwell_i), .level_o(level_o), .phase_o(phase_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: {req[3:0], start, pause, off, phase[1:0], level[11:0]}.
    // Target 10, step 3, dwell 3. The result is taken after the edge.
    localparam logic [20:0] VEC [0:NVEC-1] = '{
        {4'd2, 3'b000, 2'd0, 12'd0},   // R2 rest holds
        {4'd2, 3'b010, 2'd0, 12'd0},   // R2 pause ignored at rest
        {4'd3, 3'b100, 2'd1, 12'd0},   // R3 start
        {4'd3, 3'b000, 2'd1, 12'd3},   // R3
        {4'd3, 3'b000, 2'd1, 12'd6},   // R3
        {4'd6, 3'b010, 2'd3, 12'd6},   // R6 freeze
        {4'd6, 3'b000, 2'd3, 12'd6},   // R6 stays frozen
        {4'd7, 3'b100, 2'd1, 12'd6},   // R7 resume
        {4'd7, 3'b000, 2'd1, 12'd9},   // R7 continues
        {4'd4, 3'b000, 2'd2, 12'd10},  // R4 clamp 12 -> 10
        {4'd5, 3'b010, 2'd2, 12'd10},  // R5 pause ignored in dwell
        {4'd5, 3'b100, 2'd2, 12'd10},  // R5 start ignored in dwell
        {4'd5, 3'b000, 2'd0, 12'd0},   // R5 automatic return
        {4'd9, 3'b101, 2'd0, 12'd0},   // R9 off beats start at rest
        {4'd3, 3'b100, 2'd1, 12'd0},   // R3
        {4'd8, 3'b001, 2'd0, 12'd0},   // R8 off in climb
        {4'd3, 3'b100, 2'd1, 12'd0},   // R3
        {4'd3, 3'b000, 2'd1, 12'd3},   // R3
        {4'd6, 3'b010, 2'd3, 12'd3},   // R6
        {4'd8, 3'b001, 2'd0, 12'd0},   // R8 off in freeze
        {4'd3, 3'b100, 2'd1, 12'd0},   // R3
        {4'd3, 3'b100, 2'd1, 12'd3},   // R3 start ignored in climb
        {4'd3, 3'b000, 2'd1, 12'd6},   // R3
        {4'd3, 3'b000, 2'd1, 12'd9},   // R3
        {4'd4, 3'b000, 2'd2, 12'd10},  // R4
        {4'd8, 3'b001, 2'd0, 12'd0},   // R8 off in dwell
        {4'd3, 3'b100, 2'd1, 12'd0},   // R3
        {4'd9, 3'b101, 2'd0, 12'd0},   // R9 off beats start in climb
        {4'd2, 3'b000, 2'd0, 12'd0}    // R2
    };

    // Compare one value and report a mismatch.
    task automatic check(input int req, input int act, input int exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Apply inputs at the falling edge and wait past the next rising edge.
    task automatic cycle(input logic s, input logic p, input logic o);
        start_i = s; pause_i = p; off_i = o;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0; pause_i = 1'b0; off_i = 1'b0;
    endtask

    // Count dwell cycles of one full run with the given length.
    task automatic dwell_run(input int len, input int exp, input int req);
        int cnt = 0;
        dwell_i = DW'(len);
        cycle(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 200 && phase_o != 2'd0; i++) begin
            if (phase_o == 2'd2) cnt++;
            cycle(1'b0, 1'b0, 1'b0);
        end
        check(req, cnt, exp, "dwell cycles");
        check(req, level_o, 0, "level after dwell");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check(1, phase_o, 0, "phase in reset");
        check(1, level_o, 0, "level in reset");
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            cycle(VEC[v][16], VEC[v][15], VEC[v][14]);
            check(int'(VEC[v][20:17]), phase_o, int'(VEC[v][13:12]), $sformatf("vec %0d phase", v));
            check(int'(VEC[v][20:17]), level_o, int'(VEC[v][11:0]), $sformatf("vec %0d level", v));
        end

        // R1 reset in the middle of a climb
        cycle(1'b1, 1'b0, 1'b0);
        cycle(1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        cycle(1'b0, 1'b0, 1'b0);
        check(1, phase_o, 0, "phase after mid-run reset");
        check(1, level_o, 0, "level after mid-run reset");
        rst_n = 1'b1;

        // R5 dwell lengths 1, 5 and 0 (0 counts as 1)
        dwell_run(1, 1, 5);
        dwell_run(5, 5, 5);
        dwell_run(0, 1, 5);

        // R4 clamp without wrap-around: ceiling 4095, step 4000
        target_i = 12'd4095; step_i = 12'd4000; dwell_i = 16'd2;
        cycle(1'b1, 1'b0, 1'b0);
        cycle(1'b0, 1'b0, 1'b0);
        check(4, level_o, 4000, "first large step");
        cycle(1'b0, 1'b0, 1'b0);
        check(4, phase_o, 2, "dwell after wide sum");
        check(4, level_o, 4095, "clamped at full ceiling");
        cycle(1'b0, 1'b0, 1'b1);

        // R4 zero ceiling enters the dwell at once
        target_i = 12'd0; step_i = 12'd5;
        cycle(1'b1, 1'b0, 1'b0);
        cycle(1'b0, 1'b0, 1'b0);
        check(4, phase_o, 2, "dwell with zero ceiling");
        check(4, level_o, 0, "level with zero ceiling");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule